// File: doc/BRIEF.md
# Locked Watchdog Timer with Two-Write Feed

This block is a watchdog timer for a single clock domain. It counts down on ticks from one of three tick sources. A select input picks the source, and a fixed divide-by-4 stage sits after the mux. Each source is given as a one-cycle enable on `src_tick`, so the oscillators stay outside the block. The count is 24 bits wide.

Software uses a small write port with three registers:
- control at address 0: bit 0 arms the watchdog; bit 1 selects reset action (1) or interrupt action (0).
- timeout at address 1.
- feed at address 2.

Once armed, the watchdog cannot be disarmed by software. Only `rst_n` or the watchdog's own firing disarms it. Software keeps it alive by writing 0xAA and then 0x55 to the feed address. If the count runs out, or the feed sequence is broken, the block fires. Firing produces a one-cycle reset pulse or a one-cycle interrupt pulse. A sticky flag records that the watchdog issued a reset. A debug input freezes the count and blocks firing.

The main state machine has three states:
- `WD_OFF` goes to `WD_RUN` on an arm write.
- `WD_RUN` goes to `WD_FIRE` on expiry or on a broken feed.
- `WD_FIRE` goes to `WD_OFF` unconditionally after one cycle.

The feed tracker has two states:
- `FD_IDLE` goes to `FD_HALF` on a write of 0xAA to the feed address.
- `FD_HALF` always returns to `FD_IDLE` on the next write. That write is a good feed if it is 0x55 to the feed address, and a broken feed otherwise.

Top module: `lockdog_wdt`

## Requirements
- R1: After `rst_n` is low: `running`, `wd_reset_pulse`, `wd_irq_pulse` and `wd_flag` are 0, and `count_out` is 0.
- R2: Writing control (address 0) with bit 0 set while disarmed loads the timeout value and arms the watchdog. If nothing feeds it, it fires exactly (T+1)*4 selected ticks later, where T is the timeout value. In reset mode (bit 1 = 1), firing is a `wd_reset_pulse`.
- R3: A timeout write (address 1) of a value below 0xFF stores 0xFF. The shortest period is therefore 1024 ticks.
- R4: While armed, a control write with bit 0 clear does not disarm the watchdog. A mode change written while armed is also ignored.
- R5: A write of 0xAA (low 8 bits) to address 2, followed as the next write by 0x55 to address 2, reloads the count from the timeout register and restarts the divider. A new timeout value acts only at the next arm or reload.
- R6: While armed, any write that follows a 0xAA feed and is not 0x55 to address 2 fires the watchdog at that clock edge.
- R7: In interrupt mode (bit 1 = 0), firing is a `wd_irq_pulse` with no reset pulse, and `wd_flag` is left unchanged.
- R8: After firing, `running` is 0, and a new arm write starts a fresh period.
- R9: `wd_flag` is set by a watchdog reset pulse and is cleared only by `rst_n`.
- R10: `src_sel` values 0, 1 and 2 take ticks from `src_tick[0]`, `src_tick[1]` and `src_tick[2]`. The value 3 takes no ticks, so the count holds.
- R11: While `debug_hold` is 1, the count and divider hold and nothing fires, not even on a broken feed.
- R12: A firing pulse lasts exactly one cycle, and the reset and interrupt pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low |
| src_tick | input | 3 | One-cycle tick enables of the three sources |
| src_sel | input | 2 | Tick source select (3 = none) |
| debug_hold | input | 1 | Freeze counting and firing |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 timeout, 2 feed |
| wr_data | input | 24 | Write data |
| running | output | 1 | Watchdog armed |
| wd_reset_pulse | output | 1 | One-cycle reset request |
| wd_irq_pulse | output | 1 | One-cycle interrupt request |
| wd_flag | output | 1 | A watchdog reset has occurred |
| count_out | output | 24 | Current count value |

## Verification
The bench drives random ticks on all three sources and counts only the selected ticks between the arming edge and the firing pulse. A divider off by one tick, or a load that leaks an extra tick, therefore shows up as a wrong count. Directed cases cover the following, each with the failure it exposes:
- Timeout values below the floor: a design without the clamp fires far too early.
- A timeout rewrite before a reload: a design that loads it directly fires at the new period instead of the old one.
- A disarm or mode-change write while armed: a non-sticky design stops or fires the wrong pulse.
- Both broken-feed forms: a design that misses them never fires.
- Debug hold and source select 3: a design that leaks ticks moves the count or fires.

// File: rtl/lockdog_pkg.sv
package lockdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef enum logic {
        FD_IDLE = 1'b0,
        FD_HALF = 1'b1
    } feed_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TIME = 2'd1;
    localparam logic [1:0] ADDR_FEED = 2'd2;

    localparam logic [7:0] FEED_KEY_A = 8'hAA;
    localparam logic [7:0] FEED_KEY_B = 8'h55;

endpackage

// File: rtl/lockdog_tick_gen.sv
module lockdog_tick_gen #(
    parameter int NSRC  = 3,
    parameter int PRE_W = 2,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             hold,
    input  logic             restart,
    output logic             tick_out
);

    logic sel_tick;

    // Source mux; out-of-range select yields no ticks.
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_sel == SEL_W'(i)) begin
                sel_tick = src_tick[i];
            end
        end
    end

    generate
        if (PRE_W == 0) begin : g_nodiv
            assign tick_out = sel_tick && !hold && !restart;
        end else begin : g_div
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (restart) begin
                    pre_q <= '0;
                end else if (sel_tick && !hold) begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick_out = sel_tick && !hold && !restart && (pre_q == '1);
        end
    endgenerate

endmodule

// File: rtl/lockdog_feed_fsm.sv
module lockdog_feed_fsm
    import lockdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_byte,
    output logic       feed_ok,
    output logic       feed_bad
);

    feed_state_e st_q, st_d;
    logic        to_feed;

    assign to_feed = (wr_addr == ADDR_FEED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        if (wr_en) begin
            unique case (st_q)
                FD_IDLE: begin
                    if (to_feed && wr_byte == FEED_KEY_A) begin
                        st_d = FD_HALF;
                    end
                end
                FD_HALF: begin
                    st_d = FD_IDLE;
                    if (to_feed && wr_byte == FEED_KEY_B) begin
                        feed_ok = 1'b1;
                    end else begin
                        feed_bad = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lockdog_downcount.sv
module lockdog_downcount #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);

endmodule

// File: rtl/lockdog_wdt.sv
module lockdog_wdt
    import lockdog_pkg::*;
#(
    parameter  int CNT_W      = 24,
    parameter  int PRE_W      = 2,
    parameter  int NSRC       = 3,
    parameter  int MIN_RELOAD = 255,
    localparam int SEL_W      = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             debug_hold,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             running,
    output logic             wd_reset_pulse,
    output logic             wd_irq_pulse,
    output logic             wd_flag,
    output logic [CNT_W-1:0] count_out
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] tc_q;
    logic             mode_rst_q;
    logic             flag_q;

    logic ctrl_wr, time_wr, arm_req;
    logic feed_ok, feed_bad;
    logic load, tick4, at_zero;
    logic expire, broken;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign time_wr = wr_en && (wr_addr == ADDR_TIME);
    assign arm_req = ctrl_wr && wr_data[0] && (state_q == WD_OFF);
    assign load    = arm_req || feed_ok;

    lockdog_feed_fsm u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_byte  (wr_data[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    lockdog_tick_gen #(
        .NSRC  (NSRC),
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .src_sel  (src_sel),
        .hold     (debug_hold),
        .restart  (load),
        .tick_out (tick4)
    );

    lockdog_downcount #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (tc_q),
        .step     (tick4 && state_q == WD_RUN),
        .cnt      (count_out),
        .at_zero  (at_zero)
    );

    assign expire = tick4 && at_zero;
    assign broken = feed_bad && !debug_hold;

    // Configuration registers: timeout clamped on write, mode locked while armed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q       <= FLOOR;
            mode_rst_q <= 1'b1;
        end else begin
            if (time_wr) begin
                tc_q <= (wr_data < FLOOR) ? FLOOR : wr_data;
            end
            if (ctrl_wr && state_q == WD_OFF) begin
                mode_rst_q <= wr_data[1];
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (arm_req) state_d = WD_RUN;
            WD_RUN:  if (expire || broken) state_d = WD_FIRE;
            WD_FIRE: state_d = WD_OFF;
            default: state_d = WD_OFF;
        endcase
    end

    // Sticky record of a watchdog-issued reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (state_q == WD_FIRE && mode_rst_q) begin
            flag_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        running        = (state_q == WD_RUN);
        wd_reset_pulse = (state_q == WD_FIRE) && mode_rst_q;
        wd_irq_pulse   = (state_q == WD_FIRE) && !mode_rst_q;
        wd_flag        = flag_q;
    end

endmodule

// File: rtl/lockdog_wdt_chk.sv
module lockdog_wdt_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             debug_hold,
    input logic             wr_en,
    input logic             running,
    input logic             wd_reset_pulse,
    input logic             wd_irq_pulse,
    input logic             wd_flag,
    input logic [CNT_W-1:0] count_out
);

    p_one_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_reset_pulse && wd_irq_pulse));

    p_pulse_short_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_reset_pulse || wd_irq_pulse) |=> !(wd_reset_pulse || wd_irq_pulse));

    p_disarm_by_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (wd_reset_pulse || wd_irq_pulse));

    p_debug_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (running && debug_hold) |=> !(wd_reset_pulse || wd_irq_pulse));

    p_debug_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (running && debug_hold && !wr_en) |=> $stable(count_out));

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_pulse |=> wd_flag);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag |=> wd_flag);

endmodule

bind lockdog_wdt lockdog_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .debug_hold     (debug_hold),
    .wr_en          (wr_en),
    .running        (running),
    .wd_reset_pulse (wd_reset_pulse),
    .wd_irq_pulse   (wd_irq_pulse),
    .wd_flag        (wd_flag),
    .count_out      (count_out)
);

// File: tb/lockdog_wdt_bench.sv
module lockdog_wdt_bench;

    localparam int CLK_NS = 10;
    localparam int CNT_W  = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       src_tick = '0;
    logic [1:0]       src_sel = 2'd2;
    logic             debug_hold = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             running, wd_reset_pulse, wd_irq_pulse, wd_flag;
    logic [CNT_W-1:0] count_out;

    bit tick_on = 1'b1;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_NS/2) clk = ~clk;

    lockdog_wdt u_lockdog_wdt (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_tick       (src_tick),
        .src_sel        (src_sel),
        .debug_hold     (debug_hold),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .running        (running),
        .wd_reset_pulse (wd_reset_pulse),
        .wd_irq_pulse   (wd_irq_pulse),
        .wd_flag        (wd_flag),
        .count_out      (count_out)
    );

    // Random tick enables, each source about 3 in 4 cycles
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            src_tick[i] = tick_on && (($urandom % 4) != 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ticks(input int tc);
        int t;
        t = (tc < 255) ? 255 : tc;
        return (t + 1) * 4;
    endfunction

    function automatic logic pick(input logic [2:0] t, input logic [1:0] s);
        return (s < 2'd3) ? t[s] : 1'b0;
    endfunction

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure(output int ticks, output bit got_rst, output bit got_irq);
        ticks = 0; got_rst = 0; got_irq = 0;
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            ticks += int'(pick(src_tick, src_sel));
            @(negedge clk);
            if (wd_reset_pulse || wd_irq_pulse) begin
                got_rst = wd_reset_pulse;
                got_irq = wd_irq_pulse;
                return;
            end
        end
    endtask

    task automatic ticks_off();
        tick_on = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int  t;
        bit  gr, gi;
        logic [CNT_W-1:0] snap;
        bit  seen;
        void'($urandom(32'h1d0c5eed));

        hw_reset();
        @(negedge clk);
        check(running == 0, "R1", "running", running, 0);
        check(!wd_reset_pulse && !wd_irq_pulse, "R1", "pulses", wd_reset_pulse | wd_irq_pulse, 0);
        check(wd_flag == 0, "R1", "flag", wd_flag, 0);
        check(count_out == 0, "R1", "count", count_out, 0);

        // R2: reset-mode expiry from arm
        src_sel = 2'd2;
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        check(running == 1, "R2", "armed", running, 1);
        measure(t, gr, gi);
        check(t == exp_ticks('h100), "R2", "ticks to fire", t, exp_ticks('h100));
        check(gr && !gi, "R2", "reset pulse", gr, 1);
        check(running == 0, "R8", "disarmed after fire", running, 1'b0);
        @(negedge clk);
        check(!wd_reset_pulse, "R12", "pulse one cycle", wd_reset_pulse, 0);
        check(wd_flag == 1, "R9", "flag set", wd_flag, 1);

        // R3: clamp of a small timeout
        wr(2'd1, 5);
        wr(2'd0, 3);
        measure(t, gr, gi);
        check(t == 1024, "R3", "clamped period", t, 1024);

        // R10: sources 0 and 1
        for (int s = 0; s < 2; s++) begin
            src_sel = 2'(s);
            wr(2'd1, 'h120);
            wr(2'd0, 3);
            measure(t, gr, gi);
            check(t == exp_ticks('h120), "R10", "selected source ticks", t, exp_ticks('h120));
        end
        src_sel = 2'd2;

        // R4: sticky arm and locked mode
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        wr(2'd0, 0);
        check(running == 1, "R4", "still armed after clear write", running, 1);
        measure(t, gr, gi);
        check(gr && !gi, "R4", "mode unchanged", gi, 0);

        // R5: timeout rewrite waits for reload
        ticks_off();
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        wr(2'd1, 'h1A0);
        tick_on = 1'b1;
        measure(t, gr, gi);
        check(t == exp_ticks('h100), "R5", "old timeout kept until reload", t, exp_ticks('h100));

        // R5: valid feed reloads with new value
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        repeat (500) @(negedge clk);
        wr(2'd1, 'h1A0);
        wr(2'd2, 'hAA);
        wr(2'd2, 'h55);
        check(running == 1, "R5", "feed keeps armed", running, 1);
        measure(t, gr, gi);
        check(t == exp_ticks('h1A0), "R5", "period after feed", t, exp_ticks('h1A0));

        // R6: broken feed by other register write
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        wr(2'd2, 'hAA);
        wr(2'd1, 7);
        check(wd_reset_pulse == 1, "R6", "fire on foreign write", wd_reset_pulse, 1);

        // R9 then R7: reset clears flag, irq mode leaves it
        hw_reset();
        @(negedge clk);
        check(wd_flag == 0, "R9", "flag cleared by reset", wd_flag, 0);
        wr(2'd1, 'h100);
        wr(2'd0, 1);
        measure(t, gr, gi);
        check(gi && !gr, "R7", "irq pulse", gi, 1);
        check(t == exp_ticks('h100), "R7", "irq period", t, exp_ticks('h100));
        @(negedge clk);
        check(wd_flag == 0, "R7", "flag untouched", wd_flag, 0);

        // R6: broken feed by wrong second key, irq mode
        wr(2'd1, 'h100);
        wr(2'd0, 1);
        wr(2'd2, 'hAA);
        wr(2'd2, 'h12);
        check(wd_irq_pulse == 1, "R6", "fire on wrong key", wd_irq_pulse, 1);

        // R10: select 3 gives no ticks
        src_sel = 2'd3;
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        repeat (3000) @(negedge clk);
        check(count_out == 'h100, "R10", "count with no source", count_out, 'h100);
        check(running == 1, "R10", "armed with no source", running, 1);
        src_sel = 2'd2;
        measure(t, gr, gi);
        check(t == exp_ticks('h100), "R10", "full period after select", t, exp_ticks('h100));

        // R11: debug hold
        wr(2'd1, 'h100);
        wr(2'd0, 3);
        repeat (200) @(negedge clk);
        debug_hold = 1'b1;
        @(negedge clk);
        snap = count_out;
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (wd_reset_pulse || wd_irq_pulse) seen = 1;
        end
        check(count_out == snap, "R11", "count frozen", count_out, snap);
        check(!seen, "R11", "no fire in debug", seen, 0);
        wr(2'd2, 'hAA);
        wr(2'd0, 0);
        @(negedge clk);
        check(running == 1 && !wd_reset_pulse, "R11", "broken feed ignored", running, 1);
        debug_hold = 1'b0;
        measure(t, gr, gi);
        check(gr && t <= exp_ticks('h100), "R11", "fires after release", t, exp_ticks('h100));

        // Random arm/expire rounds
        for (int k = 0; k < 12; k++) begin
            int  tc;
            bit  md;
            tc = int'($urandom_range(0, 'h17F));
            md = 1'($urandom % 2);
            src_sel = 2'($urandom % 3);
            wr(2'd1, tc);
            wr(2'd0, md ? 3 : 1);
            measure(t, gr, gi);
            check(t == exp_ticks(tc), "R2", "random period", t, exp_ticks(tc));
            check(gr == md && gi == !md, "R12", "pulse kind", gr, md);
            check(running == 0, "R8", "disarmed", running, 0);
            @(negedge clk);
            check(!wd_reset_pulse && !wd_irq_pulse, "R12", "pulse ends", wd_reset_pulse | wd_irq_pulse, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule